// File: doc/BRIEF.md
# Servo Instruction Packet Builder

This block composes complete instruction packets for smart servos on a shared half-duplex serial line, so that a host processor does not have to assemble them. Two templates are built in. One sets a goal angle, and the other asks a servo for its present angle. The host presents a servo ID and a 16-bit data word, then raises one of two start strobes. The block then writes the framed packet into a byte buffer, one byte per clock cycle. The packet starts at buffer address 0 and carries a length field and a checksum.

A separate transmitter drains the buffer once the finished flag is high. That transmitter, the reply receiver and any arbitration for the buffer are handled elsewhere. The ID is copied into the packet unchanged, so the broadcast address 254 passes through like any individual ID from 0 to 253.

Top module: `servo_pkt_builder`

## Requirements
- R1: Every packet writes 0xFF at buffer address 0 and 0xFF at address 1, then the latched servo ID at address 2.
- R2: Address 3 holds the length field, which equals the number of parameters plus 2: 5 for a set-angle packet and 4 for a read-angle packet.
- R3: Address 4 holds the instruction code: 0x03 (write) for set-angle and 0x02 (read) for read-angle.
- R4: A set-angle packet is 9 bytes long. Its parameters at addresses 5, 6 and 7 are the register 0x1E, then the angle low byte data[7:0], then a high byte that carries only angle bits data[9:8] in bits 1:0, with data[15:10] ignored. The checksum is at address 8.
- R5: A read-angle packet is 8 bytes long. Its parameters at addresses 5 and 6 are the start register data[7:0] and the byte count 0x02. The checksum is at address 7, and data[15:8] is ignored.
- R6: The checksum byte is the bitwise inverse of the low 8 bits of the sum of the ID, the length, the instruction and all parameter bytes.
- R7: Bytes are written with the write enable high, one per cycle, at consecutive addresses starting at 0. Address 0 is written in the cycle that follows the clock edge at which the start was taken.
- R8: After reset, the write enable and the finished flag are low and the address is 0. The finished flag rises in the cycle after the last byte is written, stays high until the next build is taken, and is never high while a byte is being written.
- R9: A build starts only on a 0-to-1 transition of a strobe seen while idle. A strobe that stays high does not start another build.
- R10: If both strobes rise in the same cycle, a set-angle packet is built.
- R11: A strobe that rises while a build is in progress has no effect on the packet being built, and it does not start a build afterwards.
- R12: The ID byte is copied through unchanged for every value, including the broadcast ID 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| servo_id_i | input | 8 | Target servo ID, latched at start |
| data_i | input | 16 | Angle (set) or start register (read), latched at start |
| set_angle_i | input | 1 | Rising edge starts a set-angle packet |
| read_angle_i | input | 1 | Rising edge starts a read-angle packet |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | 8 | Buffer byte address |
| buf_data_o | output | 8 | Buffer write data |
| done_o | output | 1 | Packet complete in buffer |

## Verification
The start is taken at the clock edge where a strobe is first seen high. Byte k then appears on the buffer port k cycles after that edge. The finished flag follows one cycle after the last byte, at the ninth cycle for set-angle and the eighth for read-angle.

The bench raises the strobe before that edge and counts the edges from it. It samples each byte at the falling edge of its own cycle, so every value is read halfway between the edge that produced it and the next one. The cases where strobes are ignored are checked the same way: the byte stream is compared during the build, and the write enable is confirmed to stay low for several cycles after the finished flag.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic {CMD_SET = 1'b0, CMD_READ = 1'b1} pb_cmd_e;

  localparam logic [7:0] HDR_BYTE    = 8'hFF;
  localparam logic [7:0] INS_WRITE   = 8'h03;
  localparam logic [7:0] INS_READ    = 8'h02;
  localparam logic [7:0] REG_GOAL    = 8'h1E;
  localparam logic [7:0] RD_COUNT    = 8'h02;
  localparam int         SET_PARAMS  = 3;
  localparam int         READ_PARAMS = 2;
  localparam int         FRAME_OVH   = 6;   // 2 header, id, len, ins, checksum
  localparam int         SET_BYTES   = SET_PARAMS + FRAME_OVH;
  localparam int         READ_BYTES  = READ_PARAMS + FRAME_OVH;
  localparam int         ANGLE_W     = 10;
endpackage

// File: rtl/pb_edge.sv
module pb_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_det
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pb_template.sv
module pb_template
  import pb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  pb_cmd_e           cmd_i,
  input  logic [7:0]        id_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic [7:0]        byte_o,
  output logic [ADDR_W-1:0] last_idx_o
);
  localparam int HI_W = ANGLE_W - 8;

  logic       is_set;
  logic [7:0] len_b, ins_b, p0, p1, p2, sum, cks;

  assign is_set = (cmd_i == CMD_SET);
  assign len_b  = is_set ? 8'(SET_PARAMS + 2) : 8'(READ_PARAMS + 2);
  assign ins_b  = is_set ? INS_WRITE : INS_READ;
  assign p0     = is_set ? REG_GOAL : data_i[7:0];
  assign p1     = is_set ? data_i[7:0] : RD_COUNT;
  assign p2     = is_set ? {{(8-HI_W){1'b0}}, data_i[ANGLE_W-1:8]} : 8'h00;
  assign sum    = id_i + len_b + ins_b + p0 + p1 + p2;
  assign cks    = ~sum;

  assign last_idx_o = is_set ? ADDR_W'(SET_BYTES - 1) : ADDR_W'(READ_BYTES - 1);

  always_comb begin
    case (idx_i)
      ADDR_W'(0), ADDR_W'(1): byte_o = HDR_BYTE;
      ADDR_W'(2):             byte_o = id_i;
      ADDR_W'(3):             byte_o = len_b;
      ADDR_W'(4):             byte_o = ins_b;
      ADDR_W'(5):             byte_o = p0;
      ADDR_W'(6):             byte_o = p1;
      ADDR_W'(7):             byte_o = is_set ? p2 : cks;
      default:                byte_o = cks;
    endcase
  end
endmodule

// File: rtl/pb_seq.sv
module pb_seq
  import pb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_set_i,
  input  logic              go_read_i,
  input  logic [7:0]        id_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] last_idx_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] idx_o,
  output pb_cmd_e           cmd_o,
  output logic [7:0]        id_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      cmd_o  <= CMD_SET;
      id_o   <= '0;
      data_o <= '0;
      done_o <= 1'b0;
    end else if (!busy_o) begin
      if (go_set_i || go_read_i) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
        done_o <= 1'b0;
        cmd_o  <= go_set_i ? CMD_SET : CMD_READ;  // set wins a tie
        id_o   <= id_i;
        data_o <= data_i;
      end
    end else if (idx_o == last_idx_i) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      done_o <= 1'b1;
    end else begin
      idx_o <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/servo_pkt_builder.sv
module servo_pkt_builder
  import pb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        servo_id_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              set_angle_i,
  input  logic              read_angle_i,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              done_o
);
  localparam int NSTB = 2;

  logic [NSTB-1:0]   rise;
  logic              busy;
  logic [ADDR_W-1:0] idx, last_idx;
  pb_cmd_e           cmd_q;
  logic [7:0]        id_q;
  logic [DATA_W-1:0] data_q;

  pb_edge #(.N(NSTB)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({read_angle_i, set_angle_i}),
    .rise_o (rise)
  );

  pb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_set_i   (rise[0]),
    .go_read_i  (rise[1]),
    .id_i       (servo_id_i),
    .data_i     (data_i),
    .last_idx_i (last_idx),
    .busy_o     (busy),
    .idx_o      (idx),
    .cmd_o      (cmd_q),
    .id_o       (id_q),
    .data_o     (data_q),
    .done_o     (done_o)
  );

  pb_template #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tpl (
    .cmd_i      (cmd_q),
    .id_i       (id_q),
    .data_i     (data_q),
    .idx_i      (idx),
    .byte_o     (buf_data_o),
    .last_idx_o (last_idx)
  );

  assign buf_we_o   = busy;
  assign buf_addr_o = idx;
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              buf_we_o,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic [7:0]        buf_data_o,
  input logic              done_o
);
  a_r1_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && buf_addr_o < ADDR_W'(2)) |-> buf_data_o == 8'hFF);

  a_r7_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_we_o) |-> buf_addr_o == '0);

  a_r7_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && $past(buf_we_o)) |-> buf_addr_o == $past(buf_addr_o) + 1'b1);

  a_r8_done_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buf_we_o) |-> done_o);

  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && buf_we_o));

  a_r4_max_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> buf_addr_o <= ADDR_W'(8));
endmodule

bind servo_pkt_builder pb_checker #(.ADDR_W(ADDR_W)) i_pb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .buf_we_o   (buf_we_o),
  .buf_addr_o (buf_addr_o),
  .buf_data_o (buf_data_o),
  .done_o     (done_o)
);

// File: tb/test_servo_pkt_builder.sv
module test_servo_pkt_builder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {cmd (0 set, 1 read), id, data}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 8'h01, 16'h0200},
    {1'b0, 8'h12, 16'h03FF},
    {1'b0, 8'hFE, 16'hFC05},   // broadcast, upper data bits set
    {1'b0, 8'h00, 16'h0000},
    {1'b1, 8'h05, 16'h0024},
    {1'b1, 8'hFD, 16'hAB30},   // upper byte ignored
    {1'b1, 8'hFE, 16'h00FF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  id = '0;
  logic [15:0] dat = '0;
  logic        set_s = 1'b0, rd_s = 1'b0;
  logic        we, done;
  logic [7:0]  addr, bdata;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  servo_pkt_builder i_servo_pkt_builder (
    .clk_i(clk), .rst_ni(rst_n), .servo_id_i(id), .data_i(dat),
    .set_angle_i(set_s), .read_angle_i(rd_s),
    .buf_we_o(we), .buf_addr_o(addr), .buf_data_o(bdata), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic cmd);
    return cmd ? 8 : 9;
  endfunction

  function automatic logic [7:0] exp_byte(input logic cmd, input logic [7:0] i_d,
                                          input logic [15:0] d, input int k);
    logic [7:0] b [9];
    logic [7:0] s;
    int n;
    if (!cmd) begin
      b = '{8'hFF, 8'hFF, i_d, 8'd5, 8'h03, 8'h1E, d[7:0], {6'b0, d[9:8]}, 8'h00};
      n = 9;
    end else begin
      b = '{8'hFF, 8'hFF, i_d, 8'd4, 8'h02, d[7:0], 8'h02, 8'h00, 8'h00};
      n = 8;
    end
    s = '0;
    for (int j = 2; j < n - 1; j++) s = s + b[j];
    b[n-1] = ~s;
    return b[k];
  endfunction

  // Start a build and check every byte in its own cycle. poke >= 0 raises the
  // read strobe at that byte and holds it through and after the build (R11, R9).
  task automatic run_pkt(input logic cmd, input logic [7:0] i_d, input logic [15:0] d,
                         input bit both, input int poke);
    int n;
    logic [7:0] e;
    n = exp_len(cmd);
    @(negedge clk);
    id = i_d; dat = d;
    set_s = !cmd || both;
    rd_s  = cmd || both;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin set_s = 1'b0; rd_s = 1'b0; id = ~i_d; dat = ~d; end
      if (i == poke) rd_s = 1'b1;
      e = exp_byte(cmd, i_d, d, i);
      chk(we && addr == 8'(i) && bdata == e && !done,
          (i < 2) ? "R1" : (i == 2) ? "R12" : (i == 3) ? "R2" : (i == 4) ? "R3" :
          (i == n - 1) ? "R6" : (cmd ? "R5" : "R4"),
          {15'b0, done, we, addr, bdata}, {16'b0, 1'b1, 8'(i), e});
    end
    @(negedge clk);
    chk(done && !we, "R8", {30'b0, done, we}, 32'h2);
    if (poke >= 0) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        chk(!we && done, "R11", {30'b0, done, we}, 32'h2);
      end
      rd_s = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(!we && !done && addr == 8'h00, "R8", {22'b0, done, we, addr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_pkt(VEC[v][24], VEC[v][23:16], VEC[v][15:0], 1'b0, -1);

    // R10: both strobes rise together, set-angle packet expected
    run_pkt(1'b0, 8'h33, 16'h0155, 1'b1, -1);

    // R11: read strobe rising mid-build leaves the set packet intact
    run_pkt(1'b0, 8'h07, 16'h0123, 1'b0, 3);

    // R9: strobe held high after a build does not restart
    @(negedge clk);
    id = 8'h09; dat = 16'h0024; rd_s = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) @(negedge clk);
    @(negedge clk);
    chk(done && !we, "R9", {30'b0, done, we}, 32'h2);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(!we, "R9", {31'b0, we}, 32'h0);
    end
    rd_s = 1'b0;
    @(negedge clk);

    // R7: the next start clears done and writes address 0 first
    run_pkt(1'b1, 8'h02, 16'h0000, 1'b0, -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule